// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Conversion Controller

This block is the digital sequencer for a charge-redistribution analog-to-digital converter. The converter has a differential capacitor array with common-mode switching. A rising edge on the external conversion clock ends the sampling phase. First the switch that shorts the two array top plates is opened. The bottom-plate sample switch is released one cycle later. After that, the block resolves the result one bit at a time, most significant bit first.

No fast clock sets the pace of the bit trials. Each trial finishes only when the comparator reports that its decision is ready, through a completion strobe. The block captures the decision bit at that moment. It then moves the matching capacitor of each half to the high or low reference and starts the next trial. After the last decision, the full word is published with a one-cycle done pulse, and the block goes back to sampling.

If the next conversion edge arrives before all decisions are in, the conversion is abandoned. A one-cycle missed flag is raised, and sampling begins again. The external clock and the completion strobe are both brought into the local clock domain through a parameterised synchroniser. Only their rising edges are acted on.

Top module: `sar_async_ctrl`

## Requirements
- R1: After reset the block is sampling. `samp_ctl` and `short_ctl` are 1. Every capacitor selects common mode, so `dac_cm` is all ones and `dac_p_hi` and `dac_n_hi` are all zeros. `result` is 0, and `done` and `miss` are 0.
- R2: A rising edge on `ext_clk` first drives `short_ctl` low while `samp_ctl` stays high. `samp_ctl` goes low one cycle later.
- R3: Only the rising edge of `ext_clk` acts. A falling edge at any point of a conversion does not change its result, so the high time of `ext_clk` has no effect.
- R4: Within a conversion, one decision is taken per rising edge of `cmp_vld`, with `cmp_dec` sampled at that time. Bits are resolved from bit RES_BITS-1 down to bit 0. Without a strobe, the switch state stays unchanged however long the wait. There are exactly RES_BITS decisions.
- R5: Capacitor j, with weight 2^j for j = 0 to RES_BITS-2, is set by the decision of bit j+1. Before that decision it is at common mode: `dac_cm[j]`=1 and both hi bits are 0. After a decision of 1, the negative half goes to the high reference and the positive half goes to the low reference: `dac_n_hi[j]`=1 and `dac_p_hi[j]`=0. A decision of 0 gives the opposite. While sampling, every capacitor is at common mode.
- R6: `result` changes only together with the final decision. `done` is high for exactly one cycle, and in that cycle the block is sampling with every capacitor at common mode.
- R7: An `ext_clk` rising edge before the final decision aborts the conversion. `miss` pulses for one cycle, there is no `done`, `result` keeps its previous value, and the block returns to sampling.
- R8: Completion strobes that arrive while sampling have no effect on `result`, `done` or the switch controls.
- R9: With an ideal comparator, where the decision is 1 when the input code is at or above the trial level set by the switches, the result equals the input code for every code 0 to 2^RES_BITS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External conversion clock; its rising edge ends sampling |
| cmp_vld | input | 1 | Comparator completion strobe |
| cmp_dec | input | 1 | Comparator decision, valid while the strobe is seen |
| samp_ctl | output | 1 | Bottom-plate sample switch control |
| short_ctl | output | 1 | Top-plate shorting switch control |
| dac_cm | output | RES_BITS-1 | Per capacitor: 1 selects common mode |
| dac_p_hi | output | RES_BITS-1 | Per capacitor: positive half to high reference |
| dac_n_hi | output | RES_BITS-1 | Per capacitor: negative half to high reference |
| result | output | RES_BITS | Last completed conversion word |
| done | output | 1 | One-cycle pulse when a new result is published |
| miss | output | 1 | One-cycle pulse when a conversion is aborted |

## Verification
Some properties are checked on every cycle:
- the open-short-before-release ordering of the sample switches;
- the legality of each capacitor's three-way switch setting, and common mode throughout sampling;
- the bit index staying put without a strobe;
- the result changing only with the final decision;
- the single-cycle done pulse, and done never occurring together with an abort.

Other properties only show up in the bench scenarios. A full sweep of every input code checks that the switch pattern and the resolved word are arithmetically right, using an ideal comparator model fed from the switch outputs. Separate scenarios check that varied strobe delays and `ext_clk` fall times leave the result unchanged, that a late edge causes an abort, and that strobes during sampling are ignored.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
   typedef enum logic [1:0] {
      PH_SAMP  = 2'd0,
      PH_SPLIT = 2'd1,
      PH_CONV  = 2'd2
   } phase_e;
endpackage

// File: rtl/sar_edge.sv
`timescale 1ns/1ps
module sar_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("sar_edge: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= din;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[STAGES-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
   import sar_pkg::*;
#(
   parameter int RES_BITS = 10,
   localparam int IW = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          vld,
   output phase_e        phase,
   output logic [IW-1:0] idx,
   output logic          take,
   output logic          last,
   output logic          done,
   output logic          miss
);
   localparam logic [IW-1:0] TOP = IW'(RES_BITS - 1);

   phase_e        phase_q;
   logic [IW-1:0] idx_q;
   logic          abort;
   logic          done_q;
   logic          miss_q;

   if (RES_BITS < 2) begin : g_bad_res
      $error("sar_seq: RES_BITS must be at least 2");
   end

   always_comb begin
      take  = (phase_q == PH_CONV) && vld && !start;
      last  = (idx_q == '0);
      abort = start && (phase_q != PH_SAMP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SAMP;
         idx_q   <= TOP;
         done_q  <= 1'b0;
         miss_q  <= 1'b0;
      end else begin
         done_q <= take && last;
         miss_q <= abort;
         case (phase_q)
            PH_SAMP: begin
               if (start) begin
                  phase_q <= PH_SPLIT;
                  idx_q   <= TOP;
               end
            end
            PH_SPLIT: begin
               if (start) phase_q <= PH_SAMP;
               else       phase_q <= PH_CONV;
            end
            PH_CONV: begin
               if (start) begin
                  phase_q <= PH_SAMP;
               end else if (take) begin
                  if (last) phase_q <= PH_SAMP;
                  else      idx_q   <= idx_q - 1'b1;
               end
            end
            default: phase_q <= PH_SAMP;
         endcase
      end
   end

   assign phase = phase_q;
   assign idx   = idx_q;
   assign done  = done_q;
   assign miss  = miss_q;

   // R4
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CONV && !vld) |=> $stable(idx_q));
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R7
   miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q |-> !done_q);
endmodule

// File: rtl/sar_reg.sv
`timescale 1ns/1ps
module sar_reg #(
   parameter int RES_BITS = 10,
   localparam int IW   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1,
   localparam int NCAP = RES_BITS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv,
   input  logic                take,
   input  logic                last,
   input  logic [IW-1:0]       idx,
   input  logic                dec,
   output logic [NCAP-1:0]     dac_cm,
   output logic [NCAP-1:0]     dac_p_hi,
   output logic [NCAP-1:0]     dac_n_hi,
   output logic [RES_BITS-1:0] result
);
   logic [RES_BITS-1:1] trial_q;
   logic [RES_BITS-1:0] result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_q  <= '0;
         result_q <= '0;
      end else if (take) begin
         for (int b = 1; b < RES_BITS; b++) begin
            if (idx == IW'(b)) trial_q[b] <= dec;
         end
         if (last) result_q <= {trial_q, dec};
      end
   end

   for (genvar j = 0; j < NCAP; j++) begin : g_cap
      logic decided;
      assign decided     = conv && (IW'(j) >= idx);
      assign dac_cm[j]   = ~decided;
      assign dac_p_hi[j] = decided & ~trial_q[j+1];
      assign dac_n_hi[j] = decided &  trial_q[j+1];
   end

   assign result = result_q;

   // R5
   dac_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dac_p_hi & dac_n_hi) == '0) &&
      ((dac_cm & (dac_p_hi | dac_n_hi)) == '0) &&
      ((~dac_cm & ~(dac_p_hi | dac_n_hi)) == '0));
   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && last) |=> $stable(result_q));
endmodule

// File: rtl/sar_async_ctrl.sv
`timescale 1ns/1ps
module sar_async_ctrl
   import sar_pkg::*;
#(
   parameter int RES_BITS    = 10,
   parameter int SYNC_STAGES = 2,
   localparam int IW   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1,
   localparam int NCAP = RES_BITS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_clk,
   input  logic                cmp_vld,
   input  logic                cmp_dec,
   output logic                samp_ctl,
   output logic                short_ctl,
   output logic [NCAP-1:0]     dac_cm,
   output logic [NCAP-1:0]     dac_p_hi,
   output logic [NCAP-1:0]     dac_n_hi,
   output logic [RES_BITS-1:0] result,
   output logic                done,
   output logic                miss
);
   phase_e        phase;
   logic [IW-1:0] idx;
   logic          start;
   logic          vld_rise;
   logic          take;
   logic          last;

   if (RES_BITS < 2 || RES_BITS > 16) begin : g_bad_res
      $error("sar_async_ctrl: RES_BITS out of range 2..16");
   end

   sar_edge #(.STAGES(SYNC_STAGES)) u_ext_edge (
      .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(start)
   );

   sar_edge #(.STAGES(SYNC_STAGES)) u_vld_edge (
      .clk(clk), .rst_n(rst_n), .din(cmp_vld), .rise(vld_rise)
   );

   sar_seq #(.RES_BITS(RES_BITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .vld(vld_rise),
      .phase(phase), .idx(idx), .take(take), .last(last),
      .done(done), .miss(miss)
   );

   sar_reg #(.RES_BITS(RES_BITS)) u_reg (
      .clk(clk), .rst_n(rst_n), .conv(phase == PH_CONV),
      .take(take), .last(last), .idx(idx), .dec(cmp_dec),
      .dac_cm(dac_cm), .dac_p_hi(dac_p_hi), .dac_n_hi(dac_n_hi),
      .result(result)
   );

   assign samp_ctl  = (phase != PH_CONV);
   assign short_ctl = (phase == PH_SAMP);

   // R2
   order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(samp_ctl) |-> !$past(short_ctl));
   // R2
   short_in_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_ctl |-> samp_ctl);
   // R5
   idle_cm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      samp_ctl |-> (&dac_cm));
   // R6
   done_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (samp_ctl && short_ctl));
   // R6
   result_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
endmodule

// File: tb/sim_sar_async_ctrl.sv
`timescale 1ns/1ps
module sim_sar_async_ctrl;
   localparam int N    = 10;
   localparam int NC   = N - 1;
   localparam int FULL = (1 << NC) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_clk = 1'b0;
   logic cmp_vld = 1'b0;
   logic cmp_dec = 1'b0;
   logic samp_ctl, short_ctl, done, miss;
   logic [NC-1:0] dac_cm, dac_p_hi, dac_n_hi;
   logic [N-1:0]  result;

   int total = 0;
   int fails = 0;
   int done_cnt = 0;
   int miss_cnt = 0;

   always #2 clk = ~clk;

   sar_async_ctrl #(.RES_BITS(N), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cmp_vld(cmp_vld),
      .cmp_dec(cmp_dec), .samp_ctl(samp_ctl), .short_ctl(short_ctl),
      .dac_cm(dac_cm), .dac_p_hi(dac_p_hi), .dac_n_hi(dac_n_hi),
      .result(result), .done(done), .miss(miss)
   );

   always @(negedge clk) begin
      if (rst_n && done) done_cnt++;
      if (rst_n && miss) miss_cnt++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle_chk(input string tag);
      chk(samp_ctl && short_ctl, tag, {samp_ctl, short_ctl}, 3);
      chk(dac_cm == NC'(FULL) && dac_p_hi == '0 && dac_n_hi == '0, tag,
          int'(dac_cm), FULL);
   endtask

   // raise the conversion edge and check the switch release order
   task automatic begin_conv();
      int t;
      ext_clk = 1'b1;
      t = 0;
      while (short_ctl && t < 20) begin tick(1); t++; end
      // R2: short opens first, sample still closed
      chk(!short_ctl && samp_ctl, "R2", {samp_ctl, short_ctl}, 2);
      tick(1);
      chk(!samp_ctl, "R2", samp_ctl, 0);
   endtask

   // one bit trial with an ideal comparator driven by the switch state
   task automatic do_trial(input int v, input int k);
      int exp_cm, exp_n, exp_p, thr;
      exp_cm = ((1 << k) - 1) & FULL;
      exp_n  = (v >> 1) & ~exp_cm & FULL;
      exp_p  = ~(v >> 1) & ~exp_cm & FULL;
      // R5: decided capacitors follow their decisions, others at common mode
      chk(int'(dac_cm) == exp_cm && int'(dac_n_hi) == exp_n && int'(dac_p_hi) == exp_p,
          "R5", int'(dac_n_hi), exp_n);
      thr = 1 << (N - 1);
      for (int j = 0; j < NC; j++) begin
         if (!dac_cm[j]) thr = dac_n_hi[j] ? thr + (1 << j) : thr - (1 << j);
      end
      cmp_dec = (v >= thr);
      cmp_vld = 1'b1;
      tick(2);
      cmp_vld = 1'b0;
      tick(3 + (v + k) % 3);
   endtask

   task automatic run_conv(input int v, input int fall_at, input string tag);
      int d0;
      d0 = done_cnt;
      begin_conv();
      for (int k = N - 1; k >= 0; k--) begin
         if (N - 1 - k == fall_at) ext_clk = 1'b0;
         if (k == 0) chk(done_cnt == d0, "R4", done_cnt, d0);
         do_trial(v, k);
      end
      ext_clk = 1'b0;
      // R6
      chk(done_cnt == d0 + 1, "R6", done_cnt, d0 + 1);
      chk(int'(result) == v, tag, int'(result), v);
      idle_chk("R6");
      tick(3);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int r0, d0, m0, snap;
      tick(5);
      // R1
      idle_chk("R1");
      chk(result == '0 && !done && !miss, "R1", int'(result), 0);
      rst_n = 1'b1;
      tick(3);
      idle_chk("R1");

      // R8: strobes while sampling are ignored
      for (int i = 0; i < 3; i++) begin
         cmp_dec = 1'b1; cmp_vld = 1'b1; tick(2); cmp_vld = 1'b0; tick(3);
      end
      chk(result == '0 && done_cnt == 0, "R8", int'(result), 0);
      idle_chk("R8");

      // R3: high time of the conversion clock does not matter
      run_conv(700, 0, "R3");
      run_conv(700, 10, "R3");
      run_conv(37, 5, "R3");

      // R9: every input code
      for (int v = 0; v < (1 << N); v++) run_conv(v, v % 11, "R9");

      // R7: early edge aborts the conversion
      r0 = int'(result); d0 = done_cnt; m0 = miss_cnt;
      begin_conv();
      ext_clk = 1'b0;
      for (int k = N - 1; k > N - 5; k--) do_trial(321, k);
      snap = int'(dac_n_hi);
      tick(20);
      // R4: no strobe, no progress
      chk(int'(dac_n_hi) == snap && !samp_ctl, "R4", int'(dac_n_hi), snap);
      ext_clk = 1'b1;
      tick(6);
      chk(miss_cnt == m0 + 1, "R7", miss_cnt, m0 + 1);
      chk(done_cnt == d0, "R7", done_cnt, d0);
      chk(int'(result) == r0, "R7", int'(result), r0);
      idle_chk("R7");
      ext_clk = 1'b0;
      tick(4);
      run_conv(321, 3, "R9");
      chk(miss_cnt == m0 + 1, "R7", miss_cnt, m0 + 1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule